// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block models how a NOR-style flash word array answers bus reads while a program or sector erase is running, and what it shows once the operation has ended. Bus reads return either true array contents or a status word. In the status word, bit 7 is a completion/polling flag, bit 6 flips on each read strobe while the array is busy, and bit 5 flags a failed or refused operation. A small internal timer stands in for the real program/erase pulse engine. A small word memory stands in for the cell array. Simple strobe inputs replace a full command decoder for program, sector erase and status exit.

A one-bit polling-style setting (value 0 or 1) selects between two behaviours. It sets the meaning of bit 7 and decides whether a successful operation returns the device to array reads by itself. The setting is loaded by a four-write unlock sequence on the bus. It is cleared only by the power-on reset and is kept through the device reset. Failures always hold the status view until an exit command arrives. A programming-voltage-good input gates every program and erase.

Top module: `flash_status_responder`

## Requirements
- R1: After `por_n` the polling setting is 0 and every array word reads all ones. Asserting `rst_n` leaves the setting unchanged.
- R2: Four bus writes in this order load the setting: 0xAA to address 5, 0x55 to address 10, 0xC3 to address 5, then to address 5 a value whose bits above bit 0 are zero. Bit 0 of that last value becomes the setting. Any write that breaks the order drops the sequence back to its start and leaves the setting unchanged.
- R3: With setting 0, a successful program or erase returns the device to array reads with no command.
- R4: With setting 1, a successful operation leaves the device in the status view with bit 7 = 1, until `cmd_id_exit` is pulsed. After the exit, true data is read.
- R5: When `limit_fail` is high as the operation ends, the target is left unwritten. The status view shows bit 5 = 1, in either setting, until `cmd_id_exit`.
- R6: While busy with setting 0, bit 7 reads the inverse of bit 7 of the programmed data during a program, and reads 0 during an erase. With setting 1, bit 7 reads 0 while busy. Status word bits 4:0 and all bits above 7 read 0.
- R7: While busy, bit 6 inverts once for each rising edge of `rd_en`. Holding `rd_en` high does not invert it again, and it stops changing when the operation ends.
- R8: A program or erase aimed at a protected sector (`sect_prot` high) changes no word. The device enters the status view at once with bit 5 = 1.
- R9: When `vpp_ok` is low, program and erase commands are ignored: the device stays in array reads and the array is unchanged.
- R10: A program writes its word after PROG_CYC cycles. A sector erase sets every word of the sector selected by the top SECT_BITS address bits to all ones after ERASE_CYC cycles.
- R11: `rst_n` aborts a running operation without writing. It returns the device to array reads and clears the failure flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the polling setting and the array |
| rst_n | input | 1 | Device reset, active low; keeps the polling setting and the array |
| wr_en | input | 1 | Bus write strobe (unlock sequence) |
| rd_en | input | 1 | Bus read strobe |
| addr | input | AW | Bus word address |
| wdata | input | DW | Bus write data and program data |
| rdata | output | DW | Array word or status word |
| cmd_prog | input | 1 | Start a word program at addr with wdata |
| cmd_erase | input | 1 | Start an erase of the sector holding addr |
| cmd_id_exit | input | 1 | Leave the status view |
| limit_fail | input | 1 | Pulse-count limit exceeded, sampled as the operation ends |
| sect_prot | input | 1 | The targeted sector is protected |
| vpp_ok | input | 1 | Programming voltage is above the lockout level |

## Verification
The bench builds the block with 16-bit words, 16 addresses in four sectors, PROG_CYC = 6 and ERASE_CYC = 12. These short op windows put two polling reads and a held read strobe inside one operation, so bit 6 and bit 7 can be seen mid-flight, followed by the completion edge, all within a few cycles. The four small sectors let random erases and programs overlap often. Checks therefore hit erased-then-programmed and protected or failed words in both polling settings.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [1:0] {
    ST_READ = 2'd0,
    ST_BUSY = 2'd1,
    ST_STAT = 2'd2
  } fsr_state_e;

  // Status byte: [7] polling flag, [6] toggle, [5] failure, [4:0] zero
  function automatic logic [7:0] status_byte(input logic poll_mode, input logic busy,
                                             input logic is_erase, input logic ld7,
                                             input logic tog, input logic fail);
    logic b7;
    if (!busy)          b7 = 1'b1;
    else if (poll_mode) b7 = 1'b0;
    else if (is_erase)  b7 = 1'b0;
    else                b7 = ~ld7;
    return {b7, tog, fail, 5'b00000};
  endfunction

  function automatic int unsigned op_count_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction
endpackage

// File: rtl/fsr_cfg_unlock.sv
module fsr_cfg_unlock #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int A_FIRST = 5,
  parameter int A_SECOND = 10
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          poll_mode,
  output logic          cfg_load
);
  localparam logic [AW-1:0] AF = AW'(A_FIRST);
  localparam logic [AW-1:0] AS = AW'(A_SECOND);
  localparam logic [DW-1:0] K0 = DW'(8'hAA);
  localparam logic [DW-1:0] K1 = DW'(8'h55);
  localparam logic [DW-1:0] K2 = DW'(8'hC3);

  logic [1:0] step;
  logic       hit;

  always_comb begin
    hit = 1'b0;
    case (step)
      2'd0: hit = (addr == AF) && (wdata == K0);
      2'd1: hit = (addr == AS) && (wdata == K1);
      2'd2: hit = (addr == AF) && (wdata == K2);
      default: hit = (addr == AF) && (wdata[DW-1:1] == '0);
    endcase
  end

  assign cfg_load = wr_en && hit && (step == 2'd3);

  always_ff @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n || !rst_n) step <= 2'd0;
    else if (wr_en)       step <= hit ? step + 2'd1 : 2'd0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        poll_mode <= 1'b0;
    else if (cfg_load) poll_mode <= wdata[0];
  end
endmodule

// File: rtl/fsr_op_ctrl.sv
module fsr_op_ctrl
  import fsr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int PROG_CYC = 40,
  parameter int ERASE_CYC = 200
) (
  input  logic          clk,
  input  logic          rst_all_n,
  input  logic          cmd_prog,
  input  logic          cmd_erase,
  input  logic          cmd_id_exit,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          vpp_ok,
  input  logic          sect_prot,
  input  logic          limit_fail,
  input  logic          poll_mode,
  output fsr_state_e    state,
  output logic          op_erase,
  output logic [DW-1:0] ld_data,
  output logic [AW-1:0] ld_addr,
  output logic          fail,
  output logic          accept,
  output logic          done_evt,
  output logic          mem_we,
  output logic          mem_erase
);
  localparam int CW = op_count_width(PROG_CYC, ERASE_CYC);
  localparam logic [CW-1:0] P_LOAD = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] E_LOAD = CW'(ERASE_CYC - 1);

  logic [CW-1:0] cnt;

  assign accept    = (state == ST_READ) && vpp_ok && (cmd_prog || cmd_erase);
  assign done_evt  = (state == ST_BUSY) && (cnt == '0);
  assign mem_we    = done_evt && !limit_fail && !op_erase;
  assign mem_erase = done_evt && !limit_fail && op_erase;

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      state    <= ST_READ;
      cnt      <= '0;
      op_erase <= 1'b0;
      ld_data  <= '0;
      ld_addr  <= '0;
      fail     <= 1'b0;
    end else begin
      case (state)
        ST_READ: begin
          if (accept) begin
            op_erase <= !cmd_prog;
            ld_addr  <= addr;
            ld_data  <= wdata;
            if (sect_prot) begin
              state <= ST_STAT;
              fail  <= 1'b1;
            end else begin
              state <= ST_BUSY;
              cnt   <= cmd_prog ? P_LOAD : E_LOAD;
            end
          end
        end
        ST_BUSY: begin
          if (done_evt) begin
            if (limit_fail) begin
              state <= ST_STAT;
              fail  <= 1'b1;
            end else begin
              state <= poll_mode ? ST_STAT : ST_READ;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cmd_id_exit) begin
            state <= ST_READ;
            fail  <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fsr_array.sv
module fsr_array #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int SECT_BITS = 2
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          we,
  input  logic          erase,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [SECT_BITS-1:0] tgt_sect;

  assign tgt_sect = waddr[AW-1 -: SECT_BITS];
  assign rword    = mem[raddr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [AW-1:0] IDX = AW'(i);
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                        mem[i] <= '1;
      else if (erase && (IDX[AW-1 -: SECT_BITS] == tgt_sect)) mem[i] <= '1;
      else if (we && (waddr == IDX))                     mem[i] <= wdata;
    end
  end
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
  import fsr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int SECT_BITS = 2,
  parameter int PROG_CYC = 40,
  parameter int ERASE_CYC = 200
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          cmd_prog,
  input  logic          cmd_erase,
  input  logic          cmd_id_exit,
  input  logic          limit_fail,
  input  logic          sect_prot,
  input  logic          vpp_ok
);
  logic          rst_all_n;
  logic          poll_mode, cfg_load;
  fsr_state_e    state;
  logic          op_erase, fail, accept, done_evt, mem_we, mem_erase;
  logic [DW-1:0] ld_data;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] arr_word;
  logic          rd_q, rd_rise, toggle, busy;
  logic [7:0]    stat;

  assign rst_all_n = por_n & rst_n;

  fsr_cfg_unlock #(.AW(AW), .DW(DW)) u_cfg (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .poll_mode(poll_mode), .cfg_load(cfg_load)
  );

  fsr_op_ctrl #(.AW(AW), .DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_op (
    .clk(clk), .rst_all_n(rst_all_n), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
    .cmd_id_exit(cmd_id_exit), .addr(addr), .wdata(wdata), .vpp_ok(vpp_ok),
    .sect_prot(sect_prot), .limit_fail(limit_fail), .poll_mode(poll_mode),
    .state(state), .op_erase(op_erase), .ld_data(ld_data), .ld_addr(ld_addr),
    .fail(fail), .accept(accept), .done_evt(done_evt), .mem_we(mem_we),
    .mem_erase(mem_erase)
  );

  fsr_array #(.AW(AW), .DW(DW), .SECT_BITS(SECT_BITS)) u_arr (
    .clk(clk), .por_n(por_n), .we(mem_we), .erase(mem_erase), .waddr(ld_addr),
    .wdata(ld_data), .raddr(addr), .rword(arr_word)
  );

  assign busy    = (state == ST_BUSY);
  assign rd_rise = rd_en && !rd_q;

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      rd_q   <= 1'b0;
      toggle <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (busy && rd_rise) toggle <= ~toggle;
    end
  end

  assign stat  = status_byte(poll_mode, busy, op_erase, ld_data[7], toggle, fail);
  assign rdata = (state == ST_READ) ? arr_word : {{(DW-8){1'b0}}, stat};
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import fsr_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          poll_mode,
  input fsr_state_e    state,
  input logic          done_evt,
  input logic          limit_fail,
  input logic          cmd_id_exit,
  input logic          rd_rise,
  input logic          toggle,
  input logic          fail,
  input logic          vpp_ok,
  input logic [DW-1:0] rdata
);
  p_cfg_keep_r1: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> $stable(poll_mode));

  p_auto_return_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (done_evt && !limit_fail && !poll_mode) |=> (state == ST_READ));

  p_status_hold_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (state == ST_STAT && !cmd_id_exit) |=> (state == ST_STAT));

  p_fail_flag_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (state == ST_STAT && fail) |-> rdata[5]);

  p_busy_low7_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (state == ST_BUSY && poll_mode) |-> !rdata[7]);

  p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (state == ST_BUSY && rd_rise) |=> (toggle != $past(toggle)));

  p_toggle_hold_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !rd_rise |=> $stable(toggle));

  p_vpp_lock_r9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (state == ST_READ && !vpp_ok) |=> (state == ST_READ));
endmodule

bind flash_status_responder fsr_checker #(.DW(DW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .poll_mode(poll_mode), .state(state),
  .done_evt(done_evt), .limit_fail(limit_fail), .cmd_id_exit(cmd_id_exit),
  .rd_rise(rd_rise), .toggle(toggle), .fail(fail), .vpp_ok(vpp_ok), .rdata(rdata)
);

// File: tb/flash_status_responder_tb.sv
module flash_status_responder_tb;
  localparam int AW = 4, DW = 16, SB = 2, PC = 6, EC = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic cmd_prog = 1'b0, cmd_erase = 1'b0, cmd_id_exit = 1'b0;
  logic limit_fail = 1'b0, sect_prot = 1'b0, vpp_ok = 1'b1;

  always #10 clk = ~clk;

  flash_status_responder #(.AW(AW), .DW(DW), .SECT_BITS(SB), .PROG_CYC(PC), .ERASE_CYC(EC)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
    .cmd_id_exit(cmd_id_exit), .limit_fail(limit_fail), .sect_prot(sect_prot), .vpp_ok(vpp_ok)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model: 0 read view, 1 busy, 2 status view
  logic [DW-1:0] m_mem [DEPTH];
  int   m_view;
  bit   m_mode, m_tog, m_fail, m_erase;
  logic [DW-1:0] m_ld;

  function automatic logic [DW-1:0] exp_status(bit busy);
    logic [DW-1:0] w = '0;
    w[6] = m_tog;
    w[5] = m_fail;
    case ({busy, m_mode, m_erase})
      3'b100:  w[7] = !m_ld[7];
      3'b101, 3'b110, 3'b111: w[7] = 1'b0;
      default: w[7] = 1'b1;
    endcase
    return w;
  endfunction

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
    if (m_view == 0) return m_mem[a];
    return exp_status(m_view == 1);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(logic [AW-1:0] a, string req);
    addr = a;
    rd_en = 1'b1;
    #1 check(req, rdata, exp_read(a));
    tick();
    if (m_view == 1) m_tog = !m_tog;
    rd_en = 1'b0;
    tick();
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic set_mode(bit m);
    bus_write(4'd5, 16'h00AA);
    bus_write(4'd10, 16'h0055);
    bus_write(4'd5, 16'h00C3);
    bus_write(4'd5, {15'd0, m});
    m_mode = m;
  endtask

  task automatic exit_status();
    cmd_id_exit = 1'b1;
    tick();
    cmd_id_exit = 1'b0;
    m_view = 0;
    m_fail = 0;
  endtask

  task automatic do_op(bit er, logic [AW-1:0] a, logic [DW-1:0] d, bit prot, bit lf, bit vpp);
    int cyc = er ? EC : PC;
    addr = a; wdata = d; sect_prot = prot; limit_fail = lf; vpp_ok = vpp;
    cmd_prog = !er; cmd_erase = er;
    tick();
    cmd_prog = 1'b0; cmd_erase = 1'b0; sect_prot = 1'b0;
    if (!vpp) begin
      vpp_ok = 1'b1; limit_fail = 1'b0;
      tick();
      read_chk(a, "R9 vpp lockout ignores command");
      return;
    end
    m_erase = er; m_ld = d;
    if (prot) begin
      limit_fail = 1'b0;
      m_view = 2; m_fail = 1;
      read_chk(a, "R8 protected sector status");
      exit_status();
      read_chk(a, "R8 protected sector unchanged");
      return;
    end
    m_view = 1;
    read_chk(a, "R6 busy polling bit7");
    read_chk(a, "R7 toggle on second read");
    repeat (cyc - 4) tick();
    limit_fail = 1'b0;
    if (lf) begin
      m_view = 2; m_fail = 1;
      read_chk(a, "R5 failure held in status");
    end else begin
      if (er) begin
        for (int i = 0; i < DEPTH; i++)
          if (i[AW-1 -: SB] == a[AW-1 -: SB]) m_mem[i] = '1;
      end else begin
        m_mem[a] = d;
      end
      m_view = m_mode ? 2 : 0;
      read_chk(a, m_mode ? "R4 status view kept" : "R3 auto return to data");
    end
    if (m_view == 2) exit_status();
    read_chk(a, "R10 array content after op");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int seed;
    bit held_tog;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
    m_view = 0; m_mode = 0; m_tog = 0; m_fail = 0; m_erase = 0; m_ld = '0;
    tick(); tick();
    por_n = 1'b1;
    tick();

    // R1 reset state
    read_chk(4'd0, "R1 array erased after power-on");
    read_chk(4'd13, "R1 array erased after power-on");

    // R3 / R6 default setting 0: program then erase
    do_op(0, 4'd2, 16'h1234, 0, 0, 1);
    do_op(0, 4'd3, 16'h80F0, 0, 0, 1);
    do_op(1, 4'd1, 16'h0000, 0, 0, 1);

    // R2 setting 1 via unlock, then R4
    set_mode(1);
    do_op(0, 4'd6, 16'hA5A5, 0, 0, 1);

    // R1 device reset keeps setting 1
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    m_tog = 0;
    do_op(0, 4'd7, 16'h0077, 0, 0, 1);

    // R2 broken sequence leaves setting 1
    bus_write(4'd5, 16'h00AA);
    bus_write(4'd10, 16'h0055);
    bus_write(4'd9, 16'h00C3);
    bus_write(4'd5, 16'h00C3);
    bus_write(4'd5, 16'h0000);
    do_op(0, 4'd8, 16'h0808, 0, 0, 1);
    // R2 data with high bits set is refused
    bus_write(4'd5, 16'h00AA);
    bus_write(4'd10, 16'h0055);
    bus_write(4'd5, 16'h00C3);
    bus_write(4'd5, 16'h0100);
    do_op(0, 4'd9, 16'h0909, 0, 0, 1);

    // R7 holding the read strobe flips once only
    set_mode(0);
    addr = 4'd4; sect_prot = 0; limit_fail = 0; vpp_ok = 1;
    cmd_erase = 1'b1; tick(); cmd_erase = 1'b0;
    m_view = 1; m_erase = 1;
    rd_en = 1'b1; tick(); tick(); tick();
    rd_en = 1'b0; tick();
    held_tog = !m_tog;
    m_tog = held_tog;
    read_chk(4'd4, "R7 held strobe flips once");
    repeat (EC - 6) tick();
    for (int i = 4; i < 8; i++) m_mem[i] = '1;
    m_view = 0;
    read_chk(4'd4, "R7 toggle stops, true data");
    read_chk(4'd7, "R10 sector erase covers sector");

    // R11 reset mid operation
    addr = 4'd10; wdata = 16'h0BAD;
    cmd_prog = 1'b1; tick(); cmd_prog = 1'b0;
    tick(); tick();
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    m_view = 0; m_fail = 0; m_tog = 0;
    read_chk(4'd10, "R11 reset aborts without write");
    // R11 failure flag cleared by reset
    do_op(0, 4'd11, 16'h1111, 1, 0, 1);
    addr = 4'd12; wdata = 16'h2222; sect_prot = 1'b1;
    cmd_prog = 1'b1; tick(); cmd_prog = 1'b0; sect_prot = 1'b0;
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    read_chk(4'd12, "R11 reset leaves status view");

    // R5 failure in both settings
    do_op(0, 4'd14, 16'h4444, 0, 1, 1);
    set_mode(1);
    do_op(1, 4'd0, 16'h0000, 0, 1, 1);
    do_op(0, 4'd15, 16'h5555, 0, 0, 0);

    // constrained random mix
    for (int n = 0; n < 120; n++) begin
      bit er, pr, lf, vp;
      if ($urandom_range(0, 9) == 0) set_mode(1'($urandom_range(0, 1)));
      er = ($urandom_range(0, 3) == 0);
      pr = ($urandom_range(0, 5) == 0);
      lf = ($urandom_range(0, 5) == 0);
      vp = ($urandom_range(0, 5) != 0);
      do_op(er, AW'($urandom_range(0, DEPTH - 1)), DW'($urandom), pr, lf, vp);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule